// File: doc/BRIEF.md
# Bulk OUT Endpoint Handshake Controller

This block owns one bulk OUT endpoint buffer that is shared between a USB serial interface engine and a local CPU. The packet side delivers a one-cycle OUT token pulse for this endpoint, then the payload bytes, then an end-of-packet pulse that carries a CRC-good flag and the received data PID bit. The block writes the payload into its buffer through a byte-address counter and replies with an ACK or NAK handshake, or with no handshake at all.

The buffer is handed back and forth with a busy flag. While busy is 1 the USB side owns the buffer. Each accepted packet clears busy and raises a sticky interrupt request, and the CPU then reads the received length from the byte-count register. Once the CPU has drained the buffer it writes anything to that same register, which sets busy again. Packets that arrive while busy is 0 are NAKed and the host retries them later with the same PID. The block leaves reset already armed.

Top module: `bulk_out_ep`

## Requirements
- R1: After reset busy is 1, irq is 0, byte_cnt is 0 and the expected data toggle is DATA0 (rx_pid = 0), so the first good packet is accepted without any CPU write.
- R2: A good packet of length n that arrives while busy is 1 and whose PID matches the toggle is accepted: ACK, busy goes to 0, irq goes to 1, byte_cnt becomes n, and the payload bytes sit at buffer addresses 0 to n-1.
- R3: byte_cnt holds the length of the most recently accepted packet and does not change on NAKs, dropped packets or CPU writes.
- R4: A CPU write to the count register (cpu_sel = 0) sets busy to 1 whatever cpu_wbit holds, and the written value never reaches byte_cnt.
- R5: A good packet arriving while busy is 0 is answered with NAK, and the buffer contents, byte_cnt and irq are left unchanged.
- R6: A packet that was NAKed and is resent with the same PID after the CPU has re-armed the endpoint is accepted.
- R7: The toggle flips only when a packet is accepted. A good packet whose PID differs from the toggle while busy is 1 is ACKed, with no change to busy, byte_cnt, irq or the toggle.
- R8: A packet ending with rx_good = 0 gets no handshake and changes no state.
- R9: A packet longer than DEPTH bytes gets no handshake and changes no state. A packet of exactly DEPTH bytes is accepted.
- R10: irq is sticky. A CPU write with cpu_sel = 1 and cpu_wbit = 1 clears it, and cpu_wbit = 0 leaves it alone. If an acceptance and a clear fall in the same cycle, irq ends at 1.
- R11: hs_valid is a one-cycle pulse in the cycle after rx_end, and hs_ack = 1 means ACK. A zero-length packet is accepted with byte_cnt = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_out | input | 1 | OUT token for this endpoint; restarts the byte counter |
| rx_valid | input | 1 | Payload byte strobe |
| rx_byte | input | 8 | Payload byte |
| rx_end | input | 1 | End of data packet, one cycle |
| rx_good | input | 1 | CRC good, sampled with rx_end |
| rx_pid | input | 1 | Data PID bit (0 = DATA0, 1 = DATA1), sampled with rx_end |
| hs_valid | output | 1 | Handshake decision valid |
| hs_ack | output | 1 | 1 = ACK, 0 = NAK |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_sel | input | 1 | 0 = count/arm register, 1 = interrupt register |
| cpu_wbit | input | 1 | Write data; ignored for the count register, 1 clears irq |
| cpu_rd_addr | input | AW (6) | Buffer read address |
| cpu_rd_data | output | 8 | Buffer read data, one cycle after the address |
| byte_cnt | output | CW (7) | Length of the last accepted packet |
| busy | output | 1 | 1 = buffer owned by the USB side |
| irq | output | 1 | Sticky endpoint interrupt request |

## Verification
The bench builds the block with the default DEPTH of 64, so that a 64-byte packet fills the buffer exactly and a 65-byte packet crosses the overflow boundary. At that depth the saturating byte counter and the last buffer address are both exercised. The counter width of 7 bits leaves room for the overflow marker above 64.

// File: rtl/oep_pkg.sv
package oep_pkg;
  typedef enum logic [1:0] {
    DEC_NONE = 2'd0,
    DEC_NAK  = 2'd1,
    DEC_DROP = 2'd2,
    DEC_TAKE = 2'd3
  } oep_dec_e;
endpackage

// File: rtl/oep_buf.sv
module oep_buf #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/oep_rxcnt.sv
module oep_rxcnt #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tok_out,
  input  logic          rx_valid,
  input  logic          own,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [CW-1:0] len,
  output logic          ovf
);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (tok_out) begin
      cnt <= '0;
    end else if (rx_valid && cnt <= CAP) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign we    = rx_valid && own && (cnt < CAP);
  assign waddr = cnt[AW-1:0];
  assign len   = cnt;
  assign ovf   = cnt > CAP;

  // R9
  cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CAP + 1'b1);
endmodule

// File: rtl/oep_ctrl.sv
module oep_ctrl
  import oep_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_end,
  input  logic          rx_good,
  input  logic          rx_pid,
  input  logic [CW-1:0] len,
  input  logic          ovf,
  input  logic          arm,
  input  logic          irq_clr,
  output logic          hs_valid,
  output logic          hs_ack,
  output logic          busy,
  output logic          irq,
  output logic [CW-1:0] byte_cnt
);
  logic     tgl;
  oep_dec_e dec;

  always_comb begin
    if (!rx_end || !rx_good || ovf) dec = DEC_NONE;
    else if (!busy)                 dec = DEC_NAK;
    else if (rx_pid != tgl)         dec = DEC_DROP;
    else                            dec = DEC_TAKE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b1;
      tgl      <= 1'b0;
      irq      <= 1'b0;
      byte_cnt <= '0;
      hs_valid <= 1'b0;
      hs_ack   <= 1'b0;
    end else begin
      hs_valid <= (dec != DEC_NONE);
      hs_ack   <= (dec == DEC_DROP) || (dec == DEC_TAKE);
      if (dec == DEC_TAKE) begin
        busy     <= 1'b0;
        byte_cnt <= len;
        tgl      <= ~tgl;
      end else if (arm) begin
        busy <= 1'b1;
      end
      if (dec == DEC_TAKE) irq <= 1'b1;
      else if (irq_clr)    irq <= 1'b0;
    end
  end

  // R2
  take_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (hs_valid && hs_ack && irq));
  // R5
  nak_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hs_valid && !hs_ack) |-> $stable(byte_cnt));
  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (hs_valid && hs_ack));
  // R4
  arm_chk: assert property (@(posedge clk) disable iff (rst)
    (arm && !busy) |=> busy);
  // R11
  hs_after_end_chk: assert property (@(posedge clk) disable iff (rst)
    hs_valid |-> $past(rx_end));
endmodule

// File: rtl/bulk_out_ep.sv
module bulk_out_ep #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tok_out,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_end,
  input  logic          rx_good,
  input  logic          rx_pid,
  output logic          hs_valid,
  output logic          hs_ack,
  input  logic          cpu_wr,
  input  logic          cpu_sel,
  input  logic          cpu_wbit,
  input  logic [AW-1:0] cpu_rd_addr,
  output logic [7:0]    cpu_rd_data,
  output logic [CW-1:0] byte_cnt,
  output logic          busy,
  output logic          irq
);
  logic          we;
  logic [AW-1:0] waddr;
  logic [CW-1:0] len;
  logic          ovf;
  logic          arm;
  logic          irq_clr;

  assign arm     = cpu_wr && !cpu_sel;
  assign irq_clr = cpu_wr && cpu_sel && cpu_wbit;

  oep_rxcnt #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .tok_out(tok_out), .rx_valid(rx_valid),
    .own(busy), .we(we), .waddr(waddr), .len(len), .ovf(ovf)
  );

  oep_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk(clk), .we(we), .waddr(waddr), .wdata(rx_byte),
    .raddr(cpu_rd_addr), .rdata(cpu_rd_data)
  );

  oep_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .rx_end(rx_end), .rx_good(rx_good),
    .rx_pid(rx_pid), .len(len), .ovf(ovf), .arm(arm), .irq_clr(irq_clr),
    .hs_valid(hs_valid), .hs_ack(hs_ack), .busy(busy), .irq(irq),
    .byte_cnt(byte_cnt)
  );
endmodule

// File: tb/sim_bulk_out_ep.sv
module sim_bulk_out_ep;
  localparam int DEPTH  = 64;
  localparam int AW     = $clog2(DEPTH);
  localparam int CW     = $clog2(DEPTH + 2);
  localparam int CLK_NS = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tok_out = 0, rx_valid = 0, rx_end = 0, rx_good = 0, rx_pid = 0;
  logic [7:0]    rx_byte = '0;
  logic          cpu_wr = 0, cpu_sel = 0, cpu_wbit = 0;
  logic [AW-1:0] cpu_rd_addr = '0;
  logic          hs_valid, hs_ack, busy, irq;
  logic [7:0]    cpu_rd_data;
  logic [CW-1:0] byte_cnt;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit prev_hs = 0;
  bit exp_q[$];
  bit m_busy = 1, m_tgl = 0, m_irq = 0;
  int m_cnt = 0;

  always #(CLK_NS/2) clk = ~clk;

  bulk_out_ep #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .tok_out(tok_out), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_end(rx_end), .rx_good(rx_good), .rx_pid(rx_pid),
    .hs_valid(hs_valid), .hs_ack(hs_ack), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
    .cpu_wbit(cpu_wbit), .cpu_rd_addr(cpu_rd_addr), .cpu_rd_data(cpu_rd_data),
    .byte_cnt(byte_cnt), .busy(busy), .irq(irq)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic state_chk(string req);
    chk(busy == m_busy, {req, " busy"}, int'(busy), int'(m_busy));
    chk(irq == m_irq, {req, " irq"}, int'(irq), int'(m_irq));
    chk(int'(byte_cnt) == m_cnt, {req, " byte_cnt"}, int'(byte_cnt), m_cnt);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (hs_valid) begin
        if (prev_hs) chk(0, "R11 hs pulse width", 1, 0);
        if (exp_q.size() == 0) chk(0, "R8 R9 unexpected handshake", 1, 0);
        else begin
          bit e;
          e = exp_q.pop_front();
          chk(hs_ack == e, "R11 handshake kind", int'(hs_ack), int'(e));
        end
      end
      prev_hs = hs_valid;
    end
  end

  task automatic cpu_write(bit sel, bit wbit);
    @(negedge clk);
    cpu_wr = 1; cpu_sel = sel; cpu_wbit = wbit;
    @(negedge clk);
    cpu_wr = 0;
    if (!sel) m_busy = 1;
    else if (wbit) m_irq = 0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    @(negedge clk);
    cpu_rd_addr = AW'(a);
    @(negedge clk);
    d = cpu_rd_data;
  endtask

  task automatic send(int n, bit pid, bit good, int seed, bit clr_end);
    bit take = 0;
    if (good && n <= DEPTH) begin
      if (!m_busy) exp_q.push_back(1'b0);
      else begin
        exp_q.push_back(1'b1);
        if (pid == m_tgl) begin
          take = 1; m_busy = 0; m_cnt = n; m_tgl = ~m_tgl; m_irq = 1;
        end
      end
    end
    if (clr_end && !take) m_irq = 0;
    @(negedge clk);
    tok_out = 1;
    @(negedge clk);
    tok_out = 0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_byte = 8'((seed + i * 3) & 255);
      @(negedge clk);
    end
    rx_valid = 0;
    rx_end = 1; rx_good = good; rx_pid = pid;
    if (clr_end) begin cpu_wr = 1; cpu_sel = 1; cpu_wbit = 1; end
    @(negedge clk);
    rx_end = 0; cpu_wr = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    state_chk("R1 reset");

    // R2 first packet accepted without arm (R1)
    send(5, 0, 1, 16, 0);
    state_chk("R2 accept");
    for (int i = 0; i < 5; i++) begin
      rd(i, d);
      chk(d == 8'((16 + i * 3) & 255), "R2 buffer byte", int'(d), (16 + i * 3) & 255);
    end

    // R10 clear with bit 0 keeps irq, with bit 1 clears
    cpu_write(1, 0);
    chk(irq == 1'b1, "R10 wbit0 no clear", int'(irq), 1);
    cpu_write(1, 1);
    chk(irq == 1'b0, "R10 clear", int'(irq), 0);

    // R5 NAK while not armed
    send(3, 1, 1, 100, 0);
    state_chk("R5 nak");
    rd(0, d);
    chk(d == 8'd16, "R5 buffer unchanged", int'(d), 16);

    // R4 arm with either data value, count unchanged (R3)
    cpu_write(0, 1);
    state_chk("R4 arm data ignored R3");

    // R6 retry with same PID is accepted
    send(3, 1, 1, 100, 0);
    state_chk("R6 retry");
    rd(2, d);
    chk(d == 8'd106, "R6 buffer byte", int'(d), 106);

    // R7 mismatched PID: ACK, no state change
    cpu_write(1, 1);
    cpu_write(0, 0);
    send(4, 1, 1, 50, 0);
    state_chk("R7 mismatch");

    // R8 bad CRC
    send(4, 0, 0, 60, 0);
    state_chk("R8 bad crc");

    // R9 over length then exactly full
    send(DEPTH + 1, 0, 1, 70, 0);
    state_chk("R9 overlong");
    send(DEPTH, 0, 1, 7, 0);
    state_chk("R9 full length");
    rd(DEPTH - 1, d);
    chk(d == 8'((7 + (DEPTH - 1) * 3) & 255), "R9 last byte", int'(d),
        (7 + (DEPTH - 1) * 3) & 255);

    // R10 acceptance beats same-cycle clear
    cpu_write(1, 1);
    cpu_write(0, 0);
    send(2, 1, 1, 9, 1);
    state_chk("R10 set wins");

    // R11 zero-length packet
    cpu_write(1, 1);
    cpu_write(0, 1);
    send(0, 0, 1, 0, 0);
    state_chk("R11 zero length");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R11 missing handshake", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule